// File: doc/BRIEF.md
# Receive Character Queue with Trigger Thresholds

This block is the receive-side holding queue between a serial receiver and the host register port. It keeps up to sixteen received bytes. Next to each byte it keeps three error bits: parity, framing and break. It keeps a running occupancy count. From that count it raises a data-available indication once the count reaches one of four selectable thresholds. It also drives a DMA request line.

The receiver offers one character per cycle on the push side. The host side issues pops, and each pop moves the oldest entry into a registered read port. If a character arrives while the queue is full and no pop happens in the same cycle, that character is dropped and a one-cycle overrun pulse is raised. A summary error output is high whenever any stored entry carries an error bit.

The control side has an enable bit, a two-bit threshold code and a one-cycle clear command. With the enable bit low the queue holds only one character, like a plain holding register.

Top module: `rxq_fifo`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1, and `full`, `data_avail`, `err_any`, `overrun` and `dma_rx_ready` are 0. `rd_data` and the three `rd_*` flag outputs are 0.
- R2: Entries leave in the order they entered. Each pop with the queue non-empty places the oldest byte on `rd_data`, and its flags on `rd_perr`, `rd_ferr` and `rd_brk`, in the cycle after the popping edge.
- R3: `level` counts the stored entries, from 0 to 16. `full` is 1 at 16 when enabled. A push and a pop in the same cycle on a full queue are both accepted, and `level` stays at 16.
- R4: When enabled, `data_avail` is 1 exactly when `level` is at or above the threshold chosen by `cfg_trig`: code 0 gives 1, code 1 gives 4, code 2 gives 8 and code 3 gives 14.
- R5: A push into a full queue without a pop in the same cycle is discarded. The stored contents and `level` are unchanged, and `overrun` is 1 for exactly the one cycle after that edge.
- R6: `cfg_flush` held high at a clock edge empties the queue at that edge. A push or pop in the same cycle is ignored, and `rd_*` keep their values. The command needs no clearing: it acts only while it is high.
- R7: With `cfg_enable` low, the queue holds at most one entry, and `data_avail` and `dma_rx_ready` equal "not empty". Any change of `cfg_enable` empties the queue at the edge where it is first seen.
- R8: `err_any` is 1 exactly when at least one stored entry has its parity, framing or break bit set. It drops once the last such entry has been popped.
- R9: A pop on an empty queue is ignored. `level` stays 0 and `rd_*` keep their last values.
- R10: When enabled, `dma_rx_ready` rises when `level` reaches the threshold. It then stays high while any entry remains, even if `level` falls below the threshold, and it is 0 whenever the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | 1: sixteen-entry queue; 0: single holding entry |
| cfg_flush | input | 1 | Clear command, acts while high |
| cfg_trig | input | 2 | Threshold code: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14 |
| push_valid | input | 1 | Receiver offers a character this cycle |
| push_data | input | 8 | Received byte |
| push_perr | input | 1 | Parity error on this character |
| push_ferr | input | 1 | Framing error on this character |
| push_brk | input | 1 | Break detected on this character |
| pop | input | 1 | Host takes the oldest entry |
| rd_data | output | 8 | Last popped byte |
| rd_perr | output | 1 | Parity flag of the last popped entry |
| rd_ferr | output | 1 | Framing flag of the last popped entry |
| rd_brk | output | 1 | Break flag of the last popped entry |
| level | output | 5 | Number of stored entries |
| empty | output | 1 | No entries stored |
| full | output | 1 | Capacity reached (16 enabled, 1 disabled) |
| data_avail | output | 1 | Occupancy at or above the threshold |
| err_any | output | 1 | Some stored entry carries an error flag |
| overrun | output | 1 | One-cycle pulse after a dropped character |
| dma_rx_ready | output | 1 | DMA request for received data |

## Verification
The checker assumes `rst_n` is asserted long enough to clear every register. It also assumes the control inputs change only between clock edges. It does not assume that pushes and pops are mutually exclusive, or that a pop is only offered when data is present. The bench therefore drives every input a fixed delay after the rising edge. It offers pops on an empty queue, pushes on a full one, and both together. Enable changes are always followed by at least one idle cycle before the outputs are compared, so the clear that an enable change triggers has settled.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxq_flags_t;

  // Threshold in bytes for a 2-bit code, scaled from the queue depth.
  function automatic int unsigned rxq_threshold(input logic [1:0] code,
                                                input int unsigned depth);
    case (code)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  function automatic logic rxq_flags_bad(input rxq_flags_t f);
    return f.brk | f.ferr | f.perr;
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_flush,
  input  logic          push_valid,
  input  logic          pop,
  output logic          do_wr,
  output logic          do_rd,
  output logic          do_clr,
  output logic          evt_drop,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          overrun
);

  logic          en_q;
  logic [LW-1:0] level_q;
  logic [LW-1:0] level_d;
  logic [LW-1:0] cap;

  assign cap    = cfg_enable ? LW'(DEPTH) : LW'(1);
  assign empty  = (level_q == '0);
  assign full   = (level_q >= cap);
  assign do_clr = cfg_flush | (cfg_enable != en_q);
  assign do_rd  = pop & ~empty & ~do_clr;
  assign do_wr  = push_valid & ~do_clr & (~full | do_rd);
  assign evt_drop = push_valid & ~do_clr & full & ~do_rd;

  always_comb begin
    if (do_clr) level_d = '0;
    else        level_d = level_q + LW'(do_wr) - LW'(do_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      level_q <= '0;
      overrun <= 1'b0;
    end else begin
      en_q    <= cfg_enable;
      level_q <= level_d;
      overrun <= evt_drop;
    end
  end

  assign level = level_q;

endmodule

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic                rd,
  input  logic                clr,
  input  logic [DATA_W-1:0]   wdata,
  input  rxq_pkg::rxq_flags_t wflags,
  output logic [DATA_W-1:0]   rdata,
  output rxq_pkg::rxq_flags_t rflags,
  output logic                err_any
);

  logic [DATA_W-1:0]   data_q  [DEPTH];
  rxq_pkg::rxq_flags_t flag_q  [DEPTH];
  logic                valid_q [DEPTH];
  logic [DEPTH-1:0]    slot_bad;
  logic [AW-1:0]       wptr;
  logic [AW-1:0]       rptr;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[g]  <= '0;
        flag_q[g]  <= '0;
        valid_q[g] <= 1'b0;
      end else if (clr) begin
        valid_q[g] <= 1'b0;
      end else if (wr && wptr == AW'(g)) begin
        data_q[g]  <= wdata;
        flag_q[g]  <= wflags;
        valid_q[g] <= 1'b1;
      end else if (rd && rptr == AW'(g)) begin
        valid_q[g] <= 1'b0;
      end
    end
    assign slot_bad[g] = valid_q[g] & rxq_pkg::rxq_flags_bad(flag_q[g]);
  end

  assign err_any = |slot_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      rdata  <= '0;
      rflags <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr) wptr <= wptr + AW'(1);
      if (rd) begin
        rptr   <= rptr + AW'(1);
        rdata  <= data_q[rptr];
        rflags <= flag_q[rptr];
      end
    end
  end

endmodule

// File: rtl/rxq_trig.sv
module rxq_trig #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [1:0]    cfg_trig,
  input  logic [LW-1:0] level,
  output logic          data_avail,
  output logic          dma_rx_ready
);

  logic [LW-1:0] thr;
  logic          at_thr;
  logic          hold_q;
  logic          arm;

  assign thr    = LW'(rxq_pkg::rxq_threshold(cfg_trig, DEPTH));
  assign at_thr = (level >= thr);
  assign arm    = (level != '0) & (at_thr | hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= arm;
  end

  assign data_avail   = cfg_enable ? at_thr : (level != '0);
  assign dma_rx_ready = cfg_enable ? arm    : (level != '0);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_flush,
  input  logic [1:0]        cfg_trig,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_perr,
  input  logic              push_ferr,
  input  logic              push_brk,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              rd_brk,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              full,
  output logic              data_avail,
  output logic              err_any,
  output logic              overrun,
  output logic              dma_rx_ready
);

  logic                evt_wr;
  logic                evt_rd;
  logic                evt_clear;
  logic                evt_drop;
  rxq_pkg::rxq_flags_t in_flags;
  rxq_pkg::rxq_flags_t out_flags;

  assign in_flags.brk  = push_brk;
  assign in_flags.ferr = push_ferr;
  assign in_flags.perr = push_perr;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_flush(cfg_flush),
    .push_valid(push_valid), .pop(pop), .do_wr(evt_wr), .do_rd(evt_rd),
    .do_clr(evt_clear), .evt_drop(evt_drop), .level(level), .empty(empty),
    .full(full), .overrun(overrun)
  );

  rxq_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr(evt_wr), .rd(evt_rd), .clr(evt_clear),
    .wdata(push_data), .wflags(in_flags), .rdata(rd_data), .rflags(out_flags),
    .err_any(err_any)
  );

  rxq_trig #(.DEPTH(DEPTH)) u_trig (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_trig(cfg_trig),
    .level(level), .data_avail(data_avail), .dma_rx_ready(dma_rx_ready)
  );

  assign rd_perr = out_flags.perr;
  assign rd_ferr = out_flags.ferr;
  assign rd_brk  = out_flags.brk;

endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              pop,
  input logic [DATA_W-1:0] rd_data,
  input logic [LW-1:0]     level,
  input logic              empty,
  input logic              full,
  input logic              data_avail,
  input logic              err_any,
  input logic              overrun,
  input logic              dma_rx_ready,
  input logic              evt_clear,
  input logic              evt_drop
);

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  p_overrun_after_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |=> (overrun && $past(full)));

  p_overrun_keeps_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |=> (level == $past(level)));

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> (level == '0));

  p_pop_empty_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(rd_data));

  p_err_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> !empty);

  p_avail_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail |-> !empty);

  p_single_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && $past(!cfg_enable)) |-> level <= LW'(1));

  p_dma_quiet_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !dma_rx_ready);

endmodule

bind rxq_fifo rxq_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxq_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .pop(pop),
  .rd_data(rd_data), .level(level), .empty(empty), .full(full),
  .data_avail(data_avail), .err_any(err_any), .overrun(overrun),
  .dma_rx_ready(dma_rx_ready), .evt_clear(evt_clear), .evt_drop(evt_drop)
);

// File: tb/rxq_fifo_bench.sv
`timescale 1ns/1ps
module rxq_fifo_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_enable, cfg_flush;
  logic [1:0] cfg_trig;
  logic       push_valid, push_perr, push_ferr, push_brk, pop;
  logic [7:0] push_data;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk;
  logic [4:0] level;
  logic       empty, full, data_avail, err_any, overrun, dma_rx_ready;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rxq_fifo u_rxq_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_flush(cfg_flush),
    .cfg_trig(cfg_trig), .push_valid(push_valid), .push_data(push_data),
    .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
    .pop(pop), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
    .rd_brk(rd_brk), .level(level), .empty(empty), .full(full),
    .data_avail(data_avail), .err_any(err_any), .overrun(overrun),
    .dma_rx_ready(dma_rx_ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Advance one edge; inputs and samples sit 1 ns after the edge.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] f);
    push_valid = 1'b1; push_data = d;
    push_brk = f[2]; push_ferr = f[1]; push_perr = f[0];
    step();
    push_valid = 1'b0; push_brk = 1'b0; push_ferr = 1'b0; push_perr = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] d, input logic [2:0] f);
    pop = 1'b1;
    step();
    pop = 1'b0;
    check(req, {rd_brk, rd_ferr, rd_perr, rd_data}, {f, d});
  endtask

  task automatic flush();
    cfg_flush = 1'b1;
    step();
    cfg_flush = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 level", level, 0);
    check("R1 flags", {empty, full, data_avail, err_any, overrun, dma_rx_ready}, 6'b100000);
    check("R1 rd", {rd_brk, rd_ferr, rd_perr, rd_data}, 0);
  endtask

  task automatic t_order();
    flush();
    push(8'h11, 3'b000); push(8'h22, 3'b001); push(8'h33, 3'b010);
    push(8'h44, 3'b100); push(8'h55, 3'b000);
    check("R3 level five", level, 5);
    pop_chk("R2 first",  8'h11, 3'b000);
    pop_chk("R2 second", 8'h22, 3'b001);
    pop_chk("R2 third",  8'h33, 3'b010);
    pop_chk("R2 fourth", 8'h44, 3'b100);
    pop_chk("R2 fifth",  8'h55, 3'b000);
    check("R3 drained", {level, empty}, {5'd0, 1'b1});
  endtask

  task automatic t_trigger();
    for (int code = 0; code < 4; code++) begin
      int thr;
      thr = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
      cfg_trig = 2'(code);
      flush();
      for (int i = 0; i < thr - 1; i++) push(8'(i), 3'b000);
      check($sformatf("R4 below code %0d", code), data_avail, 0);
      push(8'hA0, 3'b000);
      check($sformatf("R4 at code %0d", code), data_avail, 1);
    end
    cfg_trig = 2'd0;
  endtask

  task automatic t_full_overrun();
    flush();
    for (int i = 0; i < 16; i++) push(8'(i), 3'b000);
    check("R3 full", {level, full}, {5'd16, 1'b1});
    push(8'hEE, 3'b111);
    check("R5 overrun pulse", overrun, 1);
    check("R5 level kept", level, 16);
    check("R5 no error from dropped", err_any, 0);
    step();
    check("R5 pulse one cycle", overrun, 0);
    pop = 1'b1; push_valid = 1'b1; push_data = 8'h77;
    step();
    pop = 1'b0; push_valid = 1'b0;
    check("R3 push+pop full", {level, overrun}, {5'd16, 1'b0});
    check("R2 head on push+pop", rd_data, 8'h00);
    for (int i = 1; i < 16; i++) pop_chk("R5 contents kept", 8'(i), 3'b000);
    pop_chk("R3 late entry", 8'h77, 3'b000);
  endtask

  task automatic t_flush_and_empty_pop();
    flush();
    push(8'h61, 3'b000); push(8'h62, 3'b001); push(8'h63, 3'b000);
    pop_chk("R6 before flush", 8'h61, 3'b000);
    cfg_flush = 1'b1; push_valid = 1'b1; push_data = 8'h99; pop = 1'b1;
    step();
    cfg_flush = 1'b0; push_valid = 1'b0; pop = 1'b0;
    check("R6 emptied", {level, empty, err_any}, {5'd0, 1'b1, 1'b0});
    check("R6 rd kept", rd_data, 8'h61);
    pop = 1'b1;
    step();
    pop = 1'b0;
    check("R9 pop empty rd", {rd_brk, rd_ferr, rd_perr, rd_data}, {3'b000, 8'h61});
    check("R9 pop empty level", level, 0);
  endtask

  task automatic t_err_summary();
    flush();
    push(8'h01, 3'b000);
    check("R8 clean entry", err_any, 0);
    push(8'h02, 3'b001); push(8'h03, 3'b000); push(8'h04, 3'b100);
    check("R8 error stored", err_any, 1);
    pop_chk("R8 pop1", 8'h01, 3'b000);
    check("R8 still set", err_any, 1);
    pop_chk("R8 pop2", 8'h02, 3'b001);
    check("R8 break remains", err_any, 1);
    pop_chk("R8 pop3", 8'h03, 3'b000);
    pop_chk("R8 pop4", 8'h04, 3'b100);
    check("R8 cleared", err_any, 0);
    push(8'h05, 3'b010);
    check("R8 framing alone", err_any, 1);
    flush();
  endtask

  task automatic t_dma();
    cfg_trig = 2'd1;
    flush();
    for (int i = 0; i < 3; i++) push(8'(i), 3'b000);
    check("R10 below", dma_rx_ready, 0);
    push(8'h03, 3'b000);
    check("R10 reached", dma_rx_ready, 1);
    for (int i = 0; i < 3; i++) pop_chk("R10 pop", 8'(i), 3'b000);
    check("R10 held", {level, dma_rx_ready, data_avail}, {5'd1, 1'b1, 1'b0});
    pop_chk("R10 last", 8'h03, 3'b000);
    check("R10 empty drop", dma_rx_ready, 0);
    cfg_trig = 2'd0;
  endtask

  task automatic t_disabled();
    cfg_trig = 2'd3;
    cfg_enable = 1'b0;
    step();
    push(8'hA1, 3'b000);
    check("R7 one entry", {level, full, data_avail, dma_rx_ready}, {5'd1, 3'b111});
    push(8'hA2, 3'b000);
    check("R7 overrun", {level, overrun}, {5'd1, 1'b1});
    pop_chk("R7 held byte", 8'hA1, 3'b000);
    push(8'hA3, 3'b000);
    cfg_enable = 1'b1;
    step();
    check("R7 enable change empties", {level, empty}, {5'd0, 1'b1});
    cfg_trig = 2'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b1; cfg_flush = 1'b0; cfg_trig = 2'd0;
    push_valid = 1'b0; push_data = '0; push_perr = 1'b0; push_ferr = 1'b0;
    push_brk = 1'b0; pop = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    step();
    t_order();
    t_trigger();
    t_full_overrun();
    t_flush_and_empty_pop();
    t_err_summary();
    t_dma();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule